// File: doc/BRIEF.md
# Doorway Direction and Occupancy Counter

This block sits behind two presence sensors mounted one after the other across a doorway: an outer sensor on the corridor side and an inner sensor on the room side. Each raw sensor line is first brought into the clock domain and then filtered, so that short spikes are dropped. A small state machine follows the order in which the two filtered sensors become blocked and clear again, and from that order it decides whether a person walked into the room or out of it.

Every finished crossing produces a one-cycle pulse, one pulse for entries and another for exits. The block keeps an occupancy figure: the number of people inside. It also gives the number still missing, which is the configured enrolment total minus the occupancy. The occupancy is clamped so that it cannot wrap in either direction. A crossing that a person starts and then abandons leaves both counts as they were.

Top module: `doorway_counter`

## Requirements
- R1: While reset is held and right after it, `presentCount` is 0, `absentCount` equals `enrolled`, and both pulses are low.
- R2: Outer only, then both, then inner only, then neither is an entry. It raises `entryPulse` once and adds one to `presentCount`.
- R3: Inner only, then both, then outer only, then neither is an exit. It raises `exitPulse` once and subtracts one from `presentCount`.
- R4: A sequence that returns to neither-blocked without reaching the far sensor alone (someone backing out) gives no pulse and leaves the counts unchanged.
- R5: A crossing is reported only once both sensors are clear. While the far sensor alone is still blocked, no pulse appears.
- R6: Each sensor level passes through a two-flop synchroniser. A new level is accepted only after it has held for `DEB_CYCLES` (default 16) consecutive clocks, so a shorter dropout has no effect.
- R7: On an entry with `presentCount` already equal to `enrolled`, the entry pulse still fires and `presentCount` stays at `enrolled`.
- R8: On an exit with `presentCount` at 0, the exit pulse still fires and `presentCount` stays at 0.
- R9: `absentCount` equals `enrolled` minus `presentCount` on every cycle, so it changes in the same cycle as `presentCount` (and is 0 if `presentCount` exceeds `enrolled`).
- R10: Each pulse is exactly one clock wide, and `entryPulse` and `exitPulse` are never high in the same cycle.
- R11: If both sensors become blocked together from the idle state, nothing is counted until both are clear again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sensOuter | input | 1 | Raw corridor-side sensor, high when blocked |
| sensInner | input | 1 | Raw room-side sensor, high when blocked |
| enrolled | input | CNT_W | Total number of people expected |
| entryPulse | output | 1 | One-cycle strobe for each entry |
| exitPulse | output | 1 | One-cycle strobe for each exit |
| presentCount | output | CNT_W | Number of people inside |
| absentCount | output | CNT_W | Enrolled total minus people inside |

## Verification
If the direction state machine ends up in the wrong state, the only outward sign is a pulse that is missing, extra or of the wrong kind. That sign shows up one clock after the filtered sensors return to clear, which is about DEB_CYCLES plus three clocks after the raw lines settle. Because of this, every scenario checks the pulse tallies and the counts both before and after the final release. A fault in the saturation or subtraction logic appears in `presentCount` and `absentCount` in the same cycle as the pulse. So the limit cases are driven right up to the enrolment total and down to zero.

// File: rtl/doorway_pkg.sv
package doorway_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_IN_FIRST, ST_IN_BOTH, ST_IN_LAST,
    ST_OUT_FIRST, ST_OUT_BOTH, ST_OUT_LAST, ST_WAIT_CLEAR
  } dirState_t;

  typedef struct packed {
    logic countUp;
    logic countDown;
  } ctrlStrobe_t;
endpackage

// File: rtl/sensor_filter.sv
module sensor_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [CW-1:0] stableCnt;
  logic syncd;

  assign syncd = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], rawIn};
  end

  // R6: accept a new level only after DEB_CYCLES equal samples in a row
  always_ff @(posedge clk) begin
    if (!rstN) begin
      level     <= 1'b0;
      stableCnt <= '0;
    end else if (syncd == level) begin
      stableCnt <= '0;
    end else if (stableCnt == LAST) begin
      level     <= syncd;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end
endmodule

// File: rtl/direction_ctrl.sv
module direction_ctrl
  import doorway_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        outerHit,
  input  logic        innerHit,
  output ctrlStrobe_t strobe
);
  dirState_t state, nextState;
  logic [1:0] seen;

  assign seen = {outerHit, innerHit};

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: case (seen)
        2'b10:   nextState = ST_IN_FIRST;
        2'b01:   nextState = ST_OUT_FIRST;
        2'b11:   nextState = ST_WAIT_CLEAR;  // R11
        default: nextState = ST_IDLE;
      endcase
      ST_IN_FIRST: case (seen)
        2'b00:   nextState = ST_IDLE;        // R4
        2'b11:   nextState = ST_IN_BOTH;
        2'b01:   nextState = ST_WAIT_CLEAR;
        default: nextState = ST_IN_FIRST;
      endcase
      ST_IN_BOTH: case (seen)
        2'b10:   nextState = ST_IN_FIRST;
        2'b01:   nextState = ST_IN_LAST;
        2'b00:   nextState = ST_IDLE;
        default: nextState = ST_IN_BOTH;
      endcase
      ST_IN_LAST: case (seen)
        2'b00: begin                         // R2, R5
          nextState      = ST_IDLE;
          strobe.countUp = 1'b1;
        end
        2'b11:   nextState = ST_IN_BOTH;
        2'b10:   nextState = ST_WAIT_CLEAR;
        default: nextState = ST_IN_LAST;
      endcase
      ST_OUT_FIRST: case (seen)
        2'b00:   nextState = ST_IDLE;
        2'b11:   nextState = ST_OUT_BOTH;
        2'b10:   nextState = ST_WAIT_CLEAR;
        default: nextState = ST_OUT_FIRST;
      endcase
      ST_OUT_BOTH: case (seen)
        2'b01:   nextState = ST_OUT_FIRST;
        2'b10:   nextState = ST_OUT_LAST;
        2'b00:   nextState = ST_IDLE;
        default: nextState = ST_OUT_BOTH;
      endcase
      ST_OUT_LAST: case (seen)
        2'b00: begin                         // R3
          nextState        = ST_IDLE;
          strobe.countDown = 1'b1;
        end
        2'b11:   nextState = ST_OUT_BOTH;
        2'b01:   nextState = ST_WAIT_CLEAR;
        default: nextState = ST_OUT_LAST;
      endcase
      default: if (seen == 2'b00) nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/count_datapath.sv
module count_datapath
  import doorway_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] enrolled,
  output logic             entryPulse,
  output logic             exitPulse,
  output logic [CNT_W-1:0] presentCount,
  output logic [CNT_W-1:0] absentCount
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      presentCount <= '0;
      entryPulse   <= 1'b0;
      exitPulse    <= 1'b0;
    end else begin
      entryPulse <= strobe.countUp;
      exitPulse  <= strobe.countDown;
      // R7, R8: clamp at the enrolled total and at zero
      if (strobe.countUp && presentCount < enrolled)
        presentCount <= presentCount + 1'b1;
      else if (strobe.countDown && presentCount != '0)
        presentCount <= presentCount - 1'b1;
    end
  end

  // R9
  assign absentCount = (presentCount > enrolled) ? '0 : enrolled - presentCount;
endmodule

// File: rtl/doorway_counter.sv
module doorway_counter
  import doorway_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sensOuter,
  input  logic             sensInner,
  input  logic [CNT_W-1:0] enrolled,
  output logic             entryPulse,
  output logic             exitPulse,
  output logic [CNT_W-1:0] presentCount,
  output logic [CNT_W-1:0] absentCount
);
  localparam int N_SENS = 2;

  logic [N_SENS-1:0] rawVec, cleanVec;
  ctrlStrobe_t strobe;

  assign rawVec = {sensInner, sensOuter};

  for (genvar i = 0; i < N_SENS; i++) begin : gFilt
    sensor_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) uFilt (
      .clk(clk), .rstN(rstN), .rawIn(rawVec[i]), .level(cleanVec[i])
    );
  end

  direction_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .outerHit(cleanVec[0]), .innerHit(cleanVec[1]),
    .strobe(strobe)
  );

  count_datapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enrolled(enrolled),
    .entryPulse(entryPulse), .exitPulse(exitPulse),
    .presentCount(presentCount), .absentCount(absentCount)
  );
endmodule

// File: rtl/doorway_counter_chk.sv
module doorway_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] enrolled,
  input logic             entryPulse,
  input logic             exitPulse,
  input logic [CNT_W-1:0] presentCount,
  input logic [CNT_W-1:0] absentCount
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(entryPulse && exitPulse)); // R10
  AST_ENTRY_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN) entryPulse |=> !entryPulse); // R10
  AST_EXIT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN) exitPulse |=> !exitPulse); // R10
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rstN) (!entryPulse && !exitPulse) |-> $stable(presentCount)); // R4
  AST_ENTRY_STEP: assert property (@(posedge clk) disable iff (!rstN) entryPulse |-> (presentCount == $past(presentCount) + 1'b1) || ($past(presentCount) >= $past(enrolled))); // R2
  AST_EXIT_STEP: assert property (@(posedge clk) disable iff (!rstN) exitPulse |-> (presentCount == $past(presentCount) - 1'b1) || ($past(presentCount) == '0)); // R3
  AST_ABSENT_SUM: assert property (@(posedge clk) disable iff (!rstN) (presentCount <= enrolled) |-> ({1'b0, absentCount} + {1'b0, presentCount} == {1'b0, enrolled})); // R9
endmodule

bind doorway_counter doorway_counter_chk #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/sim_doorway_counter.sv
module sim_doorway_counter;
  localparam int CNT_W = 8;
  localparam int SETTLE = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sensOuter = 1'b0, sensInner = 1'b0;
  logic [CNT_W-1:0] enrolled = 8'd3;
  logic entryPulse, exitPulse;
  logic [CNT_W-1:0] presentCount, absentCount;

  int checks = 0, failures = 0;
  int entryCnt = 0, exitCnt = 0, widthErr = 0;
  bit prevEntry = 0, prevExit = 0;
  int expPresent = 0;

  always #5 clk = ~clk;

  doorway_counter #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .sensOuter(sensOuter), .sensInner(sensInner),
    .enrolled(enrolled), .entryPulse(entryPulse), .exitPulse(exitPulse),
    .presentCount(presentCount), .absentCount(absentCount)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (entryPulse) entryCnt++;
      if (exitPulse) exitCnt++;
      if ((entryPulse && prevEntry) || (exitPulse && prevExit) || (entryPulse && exitPulse))
        widthErr++;
      prevEntry = entryPulse;
      prevExit  = exitPulse;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit o, bit i, int n = SETTLE);
    @(negedge clk);
    sensOuter = o;
    sensInner = i;
    repeat (n) @(negedge clk);
  endtask

  task automatic chkCounts(string req);
    chk({req, " present"}, presentCount, expPresent);
    chk({req, " absent"}, absentCount, (expPresent > enrolled) ? 0 : enrolled - expPresent);
  endtask

  task automatic tReset();
    chk("R1 present", presentCount, 0);
    chk("R1 absent", absentCount, 3);
    chk("R1 pulses", entryPulse + exitPulse, 0);
  endtask

  task automatic tEntry(string req);
    int e0 = entryCnt;
    step(1, 0); step(1, 1); step(0, 1);
    chk("R5 no pulse before clear", entryCnt, e0);
    step(0, 0);
    chk({req, " entry pulses"}, entryCnt, e0 + 1);
    if (expPresent < enrolled) expPresent++;
    chkCounts(req);
  endtask

  task automatic tExit(string req);
    int x0 = exitCnt;
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    chk({req, " exit pulses"}, exitCnt, x0 + 1);
    if (expPresent > 0) expPresent--;
    chkCounts(req);
  endtask

  task automatic tBackOut();
    int e0 = entryCnt, x0 = exitCnt;
    step(1, 0); step(1, 1); step(1, 0); step(0, 0);
    step(0, 1); step(1, 1); step(0, 1); step(0, 0);
    chk("R4 pulses", entryCnt + exitCnt, e0 + x0);
    chkCounts("R4");
  endtask

  task automatic tTogether();
    int e0 = entryCnt, x0 = exitCnt;
    step(1, 1); step(0, 1); step(0, 0);
    chk("R11 pulses", entryCnt + exitCnt, e0 + x0);
    chkCounts("R11");
  endtask

  task automatic tGlitch();
    int e0 = entryCnt;
    step(1, 0); step(1, 1); step(0, 1);
    step(0, 0, 8);
    step(0, 1);
    chk("R6 short dropout ignored", entryCnt, e0);
    step(0, 0);
    chk("R6 entry after dropout", entryCnt, e0 + 1);
    expPresent++;
    chkCounts("R6");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tEntry("R2");
    tEntry("R2");
    tExit("R3");
    tBackOut();
    tTogether();
    tGlitch();
    tEntry("R7");
    tEntry("R7 saturate");
    chk("R7 absent zero", absentCount, 0);
    tExit("R3"); tExit("R3"); tExit("R3");
    tExit("R8 saturate");
    chk("R8 exits total", exitCnt, 5);
    @(negedge clk);
    enrolled = 8'd10;
    #1;
    chk("R9 absent follows enrolled", absentCount, 10);
    chk("R10 pulse width/exclusive", widthErr, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule